// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block steers a binary-search analog-to-digital conversion. It sits beside an external DAC and one analog comparator. A start pulse begins a conversion. The block then settles one bit of the digital code on each clock, from the most significant bit down to the least. On each step it presents a trial code to the DAC. It reads the comparator, which says whether the held analog input lies above the DAC output, and it either keeps or drops the bit under test.

The trial code is always the midpoint of the interval that is still possible: the bits already decided, plus a one at the bit under test, plus zeros below it. When the least significant bit has been decided, the block latches the code into its result register and raises its end-of-conversion flag. That flag stays high until a new start is accepted. The width of the code is a parameter. The DAC, the comparator and the sample-and-hold stage all live outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, eoc_o is 0, result_o is 0 and trial_code_o is 0.
- R2: start_i high at a rising edge, while no conversion is running, is accepted. From the next cycle on, trial_code_o holds a one in bit WIDTH-1 only, which is half of full scale.
- R3: Exactly one bit is decided per clock. eoc_o rises exactly WIDTH cycles after the edge that accepted the start.
- R4: During step k (k = 0 at the MSB), trial_code_o equals the bits already decided above position WIDTH-1-k, with a one at position WIDTH-1-k and zeros below it.
- R5: A comparator value of 1 in a step keeps the bit under test at 1, which raises the lower search limit to the trial. A value of 0 clears the bit, which lowers the upper search limit to the trial.
- R6: For an analog input v whose comparator reports v > code·s, the final result is the largest code c in 0..2^WIDTH-1 with c·s < v, or 0 when there is none. For an 8-bit code and v = 7.65 of full scale 10, the result is 195 (binary 11000011). For a 3-bit code and v = 3.4 of full scale 5, the trials are 100, 110 and 101 and the result is 101.
- R7: A start that arrives while a conversion is running is ignored. The conversion finishes at the same cycle and with the same result.
- R8: result_o changes only at the completion of a conversion and stays stable while eoc_o is high.
- R9: trial_code_o is 0 whenever no conversion is running.
- R10: eoc_o falls in the cycle after a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-conversion request |
| cmp_above_i | input | 1 | Comparator: 1 when the held input exceeds the DAC output |
| trial_code_o | output | WIDTH | Trial code driven to the DAC |
| result_o | output | WIDTH | Last completed conversion code |
| eoc_o | output | 1 | End of conversion, high from completion until the next accepted start |

## Verification
A comparator model in the bench compares an input on a scale 16 times finer than the code with the trial code the block presents. The bench drives the two worked examples, an input of zero, full scale, and the values just at and just above the first code step. These directed cases separate a strict comparison from a non-strict one and check saturation at both ends. Random inputs from a fixed seed exercise every keep/clear pattern, with the trial code checked step by step against the expected binary-search path. Some conversions receive an extra start in mid-flight, and some hold the finished result while the input moves, which separates an ignored request from a restart and a latched result from a live one.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        SAR_IDLE = 2'd0,
        SAR_CONV = 2'd1,
        SAR_DONE = 2'd2
    } sar_state_e;

    typedef struct packed {
        logic load;
        logic step;
        logic finish;
    } sar_ctl_t;

    function automatic logic accept_start(sar_state_e st, logic req);
        return req && (st != SAR_CONV);
    endfunction

endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     last,
    output sar_ctl_t ctl,
    output logic     busy,
    output logic     eoc
);

    sar_state_e state_q;
    sar_state_e state_d;
    logic       eoc_q;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
            SAR_CONV: begin
                ctl.step   = 1'b1;
                ctl.finish = last;
                if (last) state_d = SAR_DONE;
            end
            default: begin
                ctl.load = accept_start(state_q, start);
                if (ctl.load) state_d = SAR_CONV;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SAR_IDLE;
            eoc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ctl.load)
                eoc_q <= 1'b0;
            else if (ctl.finish)
                eoc_q <= 1'b1;
        end
    end

    assign busy = (state_q == SAR_CONV);
    assign eoc  = eoc_q;

endmodule

// File: rtl/sar_bit_ptr.sv
module sar_bit_ptr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] ptr,
    output logic             last
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (load)
            ptr_q <= TOP_BIT;
        else if (step)
            ptr_q <= ptr_q >> 1;
    end

    assign ptr  = ptr_q;
    assign last = ptr_q[0];

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             finish,
    input  logic             busy,
    input  logic             cmp_above,
    input  logic [WIDTH-1:0] ptr,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] result
);

    logic [WIDTH-1:0] kept_q;
    logic [WIDTH-1:0] kept_d;
    logic [WIDTH-1:0] result_q;

    always_comb begin
        kept_d = kept_q;
        if (cmp_above)
            kept_d = kept_q | ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kept_q   <= '0;
            result_q <= '0;
        end else begin
            if (load)
                kept_q <= '0;
            else if (step)
                kept_q <= kept_d;
            if (finish)
                result_q <= kept_d;
        end
    end

    assign trial  = busy ? (kept_q | ptr) : '0;
    assign result = result_q;

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_above_i,
    output logic [WIDTH-1:0] trial_code_o,
    output logic [WIDTH-1:0] result_o,
    output logic             eoc_o
);
    import sar_pkg::*;

    sar_ctl_t         ctl;
    logic             busy;
    logic             last;
    logic [WIDTH-1:0] ptr;

    sar_seq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .last  (last),
        .ctl   (ctl),
        .busy  (busy),
        .eoc   (eoc_o)
    );

    sar_bit_ptr #(.WIDTH(WIDTH)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .step (ctl.step),
        .ptr  (ptr),
        .last (last)
    );

    sar_code_reg #(.WIDTH(WIDTH)) u_code (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .step      (ctl.step),
        .finish    (ctl.finish),
        .busy      (busy),
        .cmp_above (cmp_above_i),
        .ptr       (ptr),
        .trial     (trial_code_o),
        .result    (result_o)
    );

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             cmp_above_i,
    input logic [WIDTH-1:0] trial_code_o,
    input logic [WIDTH-1:0] result_o,
    input logic             eoc_o
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic             busy_obs;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] test_mask;

    assign busy_obs  = |trial_code_o;
    assign test_mask = TOP_BIT >> cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (busy_obs)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R2: an accepted start from idle leads to the half-scale trial
    assert_first_trial_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_obs && start_i) |=> (trial_code_o == TOP_BIT));

    // R3: completion exactly after the last step
    assert_length_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_obs && cnt == LAST_CNT) |=> (eoc_o && !busy_obs));

    // R3: never busy and done at once
    assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(eoc_o && busy_obs));

    // R4: bit under test set, lower bits clear
    assert_trial_shape_R4: assert property (@(posedge clk) disable iff (rst)
        busy_obs |-> (((trial_code_o & test_mask) != '0) &&
                      ((trial_code_o & (test_mask - 1'b1)) == '0)));

    // R5: comparator decides the kept bit
    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_obs && cnt != LAST_CNT) |=>
            ((|(trial_code_o & $past(test_mask))) == $past(cmp_above_i)));

    assert_lsb_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_obs && cnt == LAST_CNT) |=> (result_o[0] == $past(cmp_above_i)));

    // R7: a start in mid-flight does not abort the conversion
    assert_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_obs && start_i && cnt != LAST_CNT) |=> busy_obs);

    // R8: result held while done
    assert_result_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (eoc_o && $past(eoc_o)) |-> (result_o == $past(result_o)));

    // R10: eoc drops after an accepted start
    assert_eoc_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (eoc_o && start_i) |=> !eoc_o);

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cmp_above_i  (cmp_above_i),
    .trial_code_o (trial_code_o),
    .result_o     (result_o),
    .eoc_o        (eoc_o)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;

    localparam int W  = 8;
    localparam int W3 = 3;
    localparam int FINE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          start8 = 1'b0;
    int            vin8 = 0;
    logic          cmp8;
    logic [W-1:0]  trial8, result8;
    logic          eoc8;

    logic          start3 = 1'b0;
    int            vin3 = 0;
    logic          cmp3;
    logic [W3-1:0] trial3, result3;
    logic          eoc3;

    assign cmp8 = vin8 > (int'(trial8) * FINE);
    assign cmp3 = vin3 > (int'(trial3) * FINE);

    sar_conv_ctrl #(.WIDTH(W)) u_sar_conv_ctrl (
        .clk(clk), .rst(rst), .start_i(start8), .cmp_above_i(cmp8),
        .trial_code_o(trial8), .result_o(result8), .eoc_o(eoc8));

    sar_conv_ctrl #(.WIDTH(W3)) u_sar_conv_ctrl_w3 (
        .clk(clk), .rst(rst), .start_i(start3), .cmp_above_i(cmp3),
        .trial_code_o(trial3), .result_o(result3), .eoc_o(eoc3));

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int v, input int w);
        int top;
        int c;
        top = (1 << w) - 1;
        if (v <= 0) return 0;
        c = (v - 1) / FINE;
        return (c > top) ? top : c;
    endfunction

    function automatic int exp_trial(input int code, input int w, input int k);
        int sh;
        sh = w - k;
        return ((code >> sh) << sh) | (1 << (w - 1 - k));
    endfunction

    // 8-bit conversion; inject >= 0 pulses an extra start at that step
    task automatic convert8(input int v, input int inject);
        int ex;
        ex = exp_code(v, W);
        vin8 = v;
        @(negedge clk);
        start8 = 1'b1;
        @(negedge clk);
        start8 = 1'b0;
        check(eoc8 == 1'b0, "R10", int'(eoc8), 0);
        check(trial8 == 8'h80, "R2", int'(trial8), 128);
        for (int k = 0; k < W; k++) begin
            check(trial8 == W'(exp_trial(ex, W, k)), "R4", int'(trial8), exp_trial(ex, W, k));
            check(eoc8 == 1'b0, "R3", int'(eoc8), 0);
            start8 = (k == inject);
            @(negedge clk);
        end
        start8 = 1'b0;
        check(eoc8 == 1'b1, "R3", int'(eoc8), 1);
        check(result8 == W'(ex), inject >= 0 ? "R7" : "R6", int'(result8), ex);
        check(trial8 == '0, "R9", int'(trial8), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int v;
        int held;
        seed = 32'h5A3C;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(eoc8 == 1'b0, "R1", int'(eoc8), 0);
        check(result8 == '0, "R1", int'(result8), 0);
        check(trial8 == '0, "R1", int'(trial8), 0);

        // R6 worked example: 7.65 of 10 -> 195
        convert8(3133, -1);
        check(result8 == 8'd195, "R6", int'(result8), 195);

        // corner inputs: zero, full scale, code-step edges (R5 strict compare)
        convert8(0, -1);
        convert8(4095, -1);
        convert8(16, -1);
        check(result8 == 8'd0, "R5", int'(result8), 0);
        convert8(17, -1);
        check(result8 == 8'd1, "R5", int'(result8), 1);

        // R7 mid-flight start ignored
        convert8(2000, 3);
        convert8(777, 0);

        // R8 result held while done, input moves
        held = int'(result8);
        vin8 = 4000;
        repeat (4) begin
            @(negedge clk);
            check(result8 == W'(held), "R8", int'(result8), held);
            check(eoc8 == 1'b1, "R8", int'(eoc8), 1);
            check(trial8 == '0, "R9", int'(trial8), 0);
        end

        // random inputs
        for (int i = 0; i < 40; i++) begin
            v = int'($urandom % 4096);
            convert8(v, (i % 5 == 0) ? int'($urandom % 6) : -1);
        end

        // R6 3-bit example: 3.4 of 5 -> trials 100,110,101, result 101
        vin3 = 87;
        @(negedge clk);
        start3 = 1'b1;
        @(negedge clk);
        start3 = 1'b0;
        check(trial3 == 3'b100, "R6", int'(trial3), 4);
        @(negedge clk);
        check(trial3 == 3'b110, "R6", int'(trial3), 6);
        @(negedge clk);
        check(trial3 == 3'b101, "R6", int'(trial3), 5);
        check(eoc3 == 1'b0, "R3", int'(eoc3), 0);
        @(negedge clk);
        check(eoc3 == 1'b1, "R3", int'(eoc3), 1);
        check(result3 == 3'b101, "R6", int'(result3), 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule